// File: doc/BRIEF.md
# Sample Buffer with Raw Interrupt Status

This block takes samples from a converter that cannot be stalled, holds them in a small first-in first-out buffer and hands them to one of two consumers. The `xfer_off` mode pin picks the consumer. When it is low, a transfer engine drains the buffer over a valid/ready stream. When it is high, the CPU drains it with single-cycle read strobes, and each read returns the oldest entry on a registered data port.

Alongside the buffer, the block keeps a four-bit raw interrupt status word. One bit reports that data is ready, one that a conversion start was seen, one that acquisition is done, and one that an overflow occurred. The acquisition-done and overflow bits behave differently in the two drain modes. Software clears the three event bits by writing ones on a clear port. The data-ready bit always follows buffer occupancy.

The input stream has a ready signal, but it is only advisory. The producer never waits. `in_ready` is high when the buffer has a free slot, or when an entry leaves in the same cycle. A beat offered while `in_ready` is low is handled according to the mode. With the engine draining, the beat is dropped. With the CPU draining, the beat replaces the newest stored entry. In both cases the overflow bit is set. On the output stream, a beat moves when `out_valid` and `out_ready` are both high.

Top module: `smpbuf_irq`

## Requirements
- R1: After reset, `raw_status` is 0000, `level` is 0, `empty` is 1 and `cpu_rd_data` is 0.
- R2: `raw_status[3]` (data ready) is 1 exactly while the buffer holds at least one entry, in either mode and whether or not a conversion is running.
- R3: A `start_pulse` sets `raw_status[2]` at the next clock edge. The bit stays set until it is cleared.
- R4: With `xfer_off` low, a `stop_pulse` sets `raw_status[1]` (acquisition done) once the buffer has been drained to empty. The bit is set the cycle after the first cycle, at or after the stop, in which `level` is 0.
- R5: With `xfer_off` high, a `stop_pulse` sets `raw_status[1]` at the next clock edge, whatever the buffer occupancy. A stop still waiting for the buffer to drain also completes the cycle after `xfer_off` goes high.
- R6: With `xfer_off` low, an input beat offered while `in_ready` is low is dropped, the stored contents are unchanged, and `raw_status[0]` (overflow) is set.
- R7: With `xfer_off` high, an input beat offered while `in_ready` is low overwrites the newest stored entry, `level` stays at DEPTH, and `raw_status[0]` is set.
- R8: A 1 on `clr_w1c[2:0]` clears the matching status bit at the next edge. A set event in the same cycle wins over the clear. `clr_w1c[3]` has no effect, and hardware never clears bits 2 to 0.
- R9: A `cpu_rd` with `xfer_off` high and a non-empty buffer removes the oldest entry and shows it on `cpu_rd_data` the next cycle. A `cpu_rd` while the buffer is empty, or while `xfer_off` is low, changes neither the buffer nor `cpu_rd_data`.
- R10: `out_valid` is high exactly when `xfer_off` is low and the buffer is non-empty. `out_data` shows the oldest entry, and entries leave in arrival order, one per handshake. `level` gives the entry count.
- R11: `in_ready` is high when `level` is below DEPTH, or when an entry is removed in the same cycle. A beat offered with `in_ready` high is always stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Converter sample strobe |
| in_data | input | WIDTH | Converter sample value |
| in_ready | output | 1 | Advisory: buffer can take a beat this cycle |
| start_pulse | input | 1 | Conversion start trigger |
| stop_pulse | input | 1 | Conversion ended (complete or aborted) |
| xfer_off | input | 1 | 1 = CPU drains, 0 = transfer engine drains |
| out_valid | output | 1 | Stream beat available to the transfer engine |
| out_ready | input | 1 | Transfer engine accepts the beat |
| out_data | output | WIDTH | Oldest stored entry |
| cpu_rd | input | 1 | CPU data-register read strobe |
| cpu_rd_data | output | WIDTH | Value returned by the last effective CPU read |
| clr_w1c | input | 4 | Write-one-to-clear for status bits 2..0 |
| raw_status | output | 4 | {data ready, start trigger, acq done, overflow} |
| level | output | $clog2(DEPTH+1) | Entry count |
| empty | output | 1 | Buffer holds no entries |
| full | output | 1 | Buffer holds DEPTH entries |

## Verification
The hardest cases to reach are a stop that arrives while the transfer engine is stalled with data still buffered, and an overwrite in CPU mode. The first leaves acquisition-done pending, which is then resolved either by draining or by switching to CPU mode partway through. The second needs a full buffer with no read in the same cycle. Directed phases build each of these: they hold `out_ready` low and withhold CPU reads until the buffer fills, then raise stop or flip the mode before any drain. A long randomized phase follows, toggling the mode, reads, clears, start and stop while a queue model in the bench tracks every beat.

// File: rtl/smpbuf_pkg.sv
package smpbuf_pkg;
  localparam int unsigned ST_DRDY = 3;
  localparam int unsigned ST_TRIG = 2;
  localparam int unsigned ST_ACQ  = 1;
  localparam int unsigned ST_OVF  = 0;
  localparam int unsigned ST_W    = 4;
  localparam int unsigned EVT_W   = 3;

  typedef struct packed {
    logic trig;
    logic acq;
    logic ovf;
  } evt_t;
endpackage

// File: rtl/smpbuf_fifo.sv
module smpbuf_fifo #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned WIDTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic                         pop,
  input  logic                         replace,
  input  logic [WIDTH-1:0]             wdata,
  output logic [WIDTH-1:0]             head,
  output logic [$clog2(DEPTH+1)-1:0]   level,
  output logic                         empty,
  output logic                         full
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH+1);
  localparam logic [AW-1:0] LAST  = AW'(DEPTH-1);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    rd_ptr, wr_ptr;
  logic [CW-1:0]    cnt;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + AW'(1);
  endfunction

  function automatic logic [AW-1:0] ptr_dec(input logic [AW-1:0] p);
    return (p == '0) ? LAST : p - AW'(1);
  endfunction

  // storage: a normal push lands at the tail, a replace rewrites the newest entry
  always_ff @(posedge clk) begin
    if (push)         mem[wr_ptr]          <= wdata;
    else if (replace) mem[ptr_dec(wr_ptr)] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= ptr_inc(wr_ptr);
      if (pop)  rd_ptr <= ptr_inc(rd_ptr);
      unique case ({push, pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  assign head  = mem[rd_ptr];
  assign level = cnt;
  assign empty = (cnt == '0);
  assign full  = (cnt == FULLC);
endmodule

// File: rtl/smpbuf_drain.sv
module smpbuf_drain #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xfer_off,
  input  logic             out_ready,
  input  logic             cpu_rd,
  input  logic             in_valid,
  input  logic             empty,
  input  logic             full,
  input  logic [WIDTH-1:0] head,
  output logic             out_valid,
  output logic             in_ready,
  output logic             push,
  output logic             pop,
  output logic             replace,
  output logic             ovf_evt,
  output logic [WIDTH-1:0] cpu_rd_data
);
  logic pop_eng, pop_cpu;

  always_comb begin
    out_valid = !xfer_off && !empty;
    pop_eng   = out_valid && out_ready;
    pop_cpu   = xfer_off && cpu_rd && !empty;
    pop       = pop_eng || pop_cpu;
    in_ready  = !full || pop;
    push      = in_valid && in_ready;
    ovf_evt   = in_valid && !in_ready;
    replace   = ovf_evt && xfer_off;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cpu_rd_data <= '0;
    else if (pop_cpu) cpu_rd_data <= head;
  end
endmodule

// File: rtl/smpbuf_status.sv
module smpbuf_status
  import smpbuf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_pulse,
  input  logic             stop_pulse,
  input  logic             xfer_off,
  input  logic             empty,
  input  logic             ovf_evt,
  input  logic [EVT_W-1:0] clr,
  output logic [ST_W-1:0]  raw_status
);
  evt_t             evt;
  logic             stop_pend;
  logic [EVT_W-1:0] set_vec;
  logic [EVT_W-1:0] sticky;

  always_comb begin
    evt.trig = start_pulse;
    evt.acq  = (stop_pulse || stop_pend) && (xfer_off || empty);
    evt.ovf  = ovf_evt;
    set_vec  = evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stop_pend <= 1'b0;
    else if (evt.acq) stop_pend <= 1'b0;
    else if (stop_pulse) stop_pend <= 1'b1;
  end

  for (genvar g = 0; g < EVT_W; g++) begin : g_sticky
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          sticky[g] <= 1'b0;
      else if (set_vec[g]) sticky[g] <= 1'b1;
      else if (clr[g])     sticky[g] <= 1'b0;
    end
  end

  always_comb begin
    raw_status          = '0;
    raw_status[ST_DRDY] = !empty;
    raw_status[ST_TRIG] = sticky[2];
    raw_status[ST_ACQ]  = sticky[1];
    raw_status[ST_OVF]  = sticky[0];
  end
endmodule

// File: rtl/smpbuf_irq.sv
module smpbuf_irq
  import smpbuf_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned WIDTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic [WIDTH-1:0]           in_data,
  output logic                       in_ready,
  input  logic                       start_pulse,
  input  logic                       stop_pulse,
  input  logic                       xfer_off,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [WIDTH-1:0]           out_data,
  input  logic                       cpu_rd,
  output logic [WIDTH-1:0]           cpu_rd_data,
  input  logic [3:0]                 clr_w1c,
  output logic [ST_W-1:0]            raw_status,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic                       empty,
  output logic                       full
);
  logic push, pop, replace, ovf_evt;

  smpbuf_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) i_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .replace(replace),
    .wdata(in_data), .head(out_data), .level(level), .empty(empty), .full(full)
  );

  smpbuf_drain #(.WIDTH(WIDTH)) i_drain (
    .clk(clk), .rst_n(rst_n), .xfer_off(xfer_off), .out_ready(out_ready),
    .cpu_rd(cpu_rd), .in_valid(in_valid), .empty(empty), .full(full),
    .head(out_data), .out_valid(out_valid), .in_ready(in_ready), .push(push),
    .pop(pop), .replace(replace), .ovf_evt(ovf_evt), .cpu_rd_data(cpu_rd_data)
  );

  smpbuf_status i_status (
    .clk(clk), .rst_n(rst_n), .start_pulse(start_pulse), .stop_pulse(stop_pulse),
    .xfer_off(xfer_off), .empty(empty), .ovf_evt(ovf_evt),
    .clr(clr_w1c[EVT_W-1:0]), .raw_status(raw_status)
  );
endmodule

// File: rtl/smpbuf_irq_chk.sv
module smpbuf_irq_chk #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned WIDTH = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       in_valid,
  input logic                       in_ready,
  input logic                       start_pulse,
  input logic                       stop_pulse,
  input logic                       xfer_off,
  input logic                       out_valid,
  input logic                       cpu_rd,
  input logic [WIDTH-1:0]           cpu_rd_data,
  input logic [3:0]                 clr_w1c,
  input logic [3:0]                 raw_status,
  input logic [$clog2(DEPTH+1)-1:0] level,
  input logic                       empty
);
  // R10
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= ($clog2(DEPTH+1))'(DEPTH));

  // R2
  drdy_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !raw_status[3]);

  // R3
  trig_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> raw_status[2]);

  // R4
  acq_eng_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_off && stop_pulse && empty) |=> raw_status[1]);

  // R5
  acq_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_off && stop_pulse) |=> raw_status[1]);

  // R6
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> raw_status[0]);

  // R8
  acq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_status[1] && !clr_w1c[1]) |=> raw_status[1]);

  // R8
  drdy_noclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_w1c[3] && !empty && !out_valid && !(xfer_off && cpu_rd)) |=> raw_status[3]);

  // R9
  rd_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && empty) |=> $stable(cpu_rd_data));

  // R10
  ovalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (!xfer_off && !empty));
endmodule

bind smpbuf_irq smpbuf_irq_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) i_chk (.*);

// File: tb/test_smpbuf_irq.sv
`timescale 1ns/1ps
module test_smpbuf_irq;
  localparam int D = 4;
  localparam int W = 16;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, start_pulse = 0, stop_pulse = 0, xfer_off = 0;
  logic out_ready = 0, cpu_rd = 0;
  logic [W-1:0] in_data = '0;
  logic [3:0] clr_w1c = '0;
  logic in_ready, out_valid, empty, full;
  logic [W-1:0] out_data, cpu_rd_data;
  logic [3:0] raw_status;
  logic [$clog2(D+1)-1:0] level;

  always #2 clk = ~clk;

  smpbuf_irq #(.DEPTH(D), .WIDTH(W)) i_smpbuf_irq (.*);

  int nchk = 0, nerr = 0;
  int q[$];
  bit [2:0] st;
  bit pend;
  int rdval = 0;

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  task automatic check_regs();
    chk("R2 data ready", raw_status[3], q.size() != 0);
    chk("R3 start trig", raw_status[2], st[2]);
    chk(xfer_off ? "R5 acq done" : "R4 acq done", raw_status[1], st[1]);
    chk(xfer_off ? "R7 overflow" : "R6 overflow", raw_status[0], st[0]);
    chk("R10 level", level, q.size());
    chk("R9 cpu data", cpu_rd_data, rdval);
    if (q.size() != 0) chk("R10 head", out_data, q[0]);
  endtask

  function automatic bit model_pop();
    return (q.size() > 0) && ((!xfer_off && out_ready) || (xfer_off && cpu_rd));
  endfunction

  task automatic check_comb();
    chk("R10 out_valid", out_valid, !xfer_off && q.size() > 0);
    chk("R11 in_ready", in_ready, (q.size() < D) || model_pop());
  endtask

  task automatic model();
    int lvl = q.size();
    bit p = model_pop();
    bit ovf = 0, acq;
    if (p) begin
      if (xfer_off) rdval = q[0];
      void'(q.pop_front());
    end
    if (in_valid) begin
      if (lvl < D || p) q.push_back(in_data);
      else begin
        ovf = 1;
        if (xfer_off) q[q.size()-1] = in_data;
      end
    end
    acq = (stop_pulse || pend) && (xfer_off || lvl == 0);
    if (acq) pend = 0; else if (stop_pulse) pend = 1;
    st = (st & ~clr_w1c[2:0]) | {start_pulse, acq, ovf};
  endtask

  task automatic step(input bit v, input int d, input bit s, input bit p,
                      input bit xo, input bit ordy, input bit cr, input bit [3:0] c);
    @(negedge clk);
    check_regs();
    in_valid = v; in_data = W'(d); start_pulse = s; stop_pulse = p;
    xfer_off = xo; out_ready = ordy; cpu_rd = cr; clr_w1c = c;
    #1 check_comb();
    @(posedge clk);
    model();
  endtask

  task automatic idle(input int n, input bit xo);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, xo, 0, 0, 4'h0);
  endtask

  initial begin
    #(4*150000);
    nerr++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 status", raw_status, 0);
    chk("R1 level", level, 0);
    chk("R1 empty", empty, 1);
    chk("R1 cpu data", cpu_rd_data, 0);
    rst_n = 1;
    idle(2, 0);
    // R3 start trigger, set wins over clear in the same cycle (R8)
    step(0, 0, 1, 0, 0, 0, 0, 4'h4);
    idle(1, 0);
    step(0, 0, 0, 0, 0, 0, 0, 4'h4);
    // engine mode: fill with stall, then overflow drop (R6, R11)
    for (int i = 0; i < 6; i++) step(1, 100 + i, 0, 0, 0, 0, 0, 4'h0);
    // R8: clr bit3 ignored, stop while data waits (R4 pending)
    step(0, 0, 0, 1, 0, 0, 0, 4'h8);
    idle(2, 0);
    for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 0, 1, 0, 4'h0);
    idle(2, 0);
    step(0, 0, 0, 0, 0, 0, 0, 4'h3);
    // R9: cpu read ignored in engine mode
    step(1, 7, 0, 0, 0, 0, 0, 4'h0);
    step(0, 0, 0, 0, 0, 0, 1, 4'h0);
    // CPU mode: fill and overwrite newest (R7)
    for (int i = 0; i < 6; i++) step(1, 200 + i, 0, 0, 1, 0, 0, 4'h0);
    // R5 stop with full buffer
    step(0, 0, 0, 1, 1, 0, 0, 4'h0);
    for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 1, 0, 1, 4'h0);
    // read while full with a new beat in the same cycle (R11)
    step(0, 0, 0, 0, 1, 0, 0, 4'h3);
    for (int i = 0; i < 4; i++) step(1, 300 + i, 0, 0, 1, 0, 0, 4'h0);
    step(1, 399, 0, 0, 1, 0, 1, 4'h0);
    // pending stop resolved by switching to CPU mode (R5)
    step(0, 0, 0, 0, 0, 0, 0, 4'h2);
    step(0, 0, 0, 1, 0, 0, 0, 4'h0);
    idle(2, 0);
    step(0, 0, 0, 0, 1, 0, 0, 4'h0);
    // enabling the engine drains the rest (R2, R10)
    for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 0, 1, 0, 4'h0);
    // randomized traffic
    for (int i = 0; i < 4000; i++) begin
      step(($urandom % 3) != 0, $urandom % 65536, ($urandom % 40) == 0,
           ($urandom % 30) == 0, (i / 300) % 2 == 1, ($urandom % 3) == 0,
           ($urandom % 3) == 0, (($urandom % 10) == 0) ? 4'($urandom) : 4'h0);
    end
    @(negedge clk);
    check_regs();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule